// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This unit sits between an interrupt source layer and one processor. It holds at most one pending external interrupt and decides whether each offered interrupt is taken or bounced. The decision weighs the offered priority against the processor's current priority ceiling and against the priority of whatever is already waiting. Lower numbers are more favoured, and 0xFF is the least favoured level. A taken interrupt can later be displaced by a more favoured one. The displaced source is then handed back to the source layer through a reject pulse, so that it can be offered again after a resend request.

The processor drives four commands, one per cycle:
- an accept read, which returns the 32-bit status word and claims the pending interrupt;
- an end-of-interrupt write, which restores the ceiling and notifies the source layer;
- a ceiling write;
- a write to the inter-processor message priority register.

When the message priority is more favoured than the ceiling, the unit raises a self-generated inter-processor interrupt with source number 2.

A command and an offer may arrive in the same cycle. The command is applied first, and the offer is then judged against the resulting state. Each stage has its own reject channel.

Top module: `xicp_present_unit`

## Requirements
- R1: Reset leaves the interrupt line low and no pulse active. The ceiling and the pending source number are 0, the pending priority is 0xFF and the message priority is 0xFF. An accept read straight after reset therefore returns 0x00000000 and sets the ceiling to 0xFF.
- R2: An offer is bounced, with offer_rej_valid high and offer_rej_src equal to the offered number, when its priority is greater than or equal to the ceiling. It is also bounced when an interrupt is pending whose priority is less than or equal to the offered priority.
- R3: An offer that is not bounced is taken. Its number and priority become the pending ones and irq_out goes high. Any source that was pending before is reported on offer_rej_src.
- R4: An accept read (cmd_op 0) returns {ceiling[31:24], pending number[23:0]} on rd_data with rd_valid. It then drops irq_out, copies the pending priority into the ceiling and clears the pending number.
- R5: An end-of-interrupt write (cmd_op 1) pulses eoi_valid with eoi_src equal to cmd_data[23:0]. It loads the ceiling from cmd_data[31:24] and, if nothing is pending, issues a resend.
- R6: A ceiling write (cmd_op 2, value in cmd_data[7:0]) to a value below the old ceiling loads the new ceiling. If an interrupt is pending whose priority is greater than or equal to the new value, the write also clears that interrupt, drops irq_out and reports the source on cmd_rej_src.
- R7: A ceiling write to a value greater than or equal to the old ceiling issues a resend (resend_req pulse) when nothing is pending.
- R8: A resend first loads the inter-processor interrupt when the message priority is below the ceiling. This sets the pending number to 2, sets the pending priority to the message priority and raises irq_out.
- R9: A message priority write (cmd_op 3, value in cmd_data[7:0]) below the ceiling runs the inter-processor check. The check does nothing if a pending interrupt's priority is less than or equal to the message priority. Otherwise it reports any pending source on cmd_rej_src and loads source 2.
- R10: When a command and an offer arrive in the same cycle, the offer is judged on the state the command leaves.
- R11: All outputs are registered and appear one cycle after the command or offer. Pulses last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 accept, 1 end-of-interrupt, 2 ceiling write, 3 message priority write |
| cmd_data | input | 32 | Command operand |
| offer_valid | input | 1 | Offer strobe from the source layer |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Accept read data valid |
| rd_data | output | 32 | Status word returned by an accept read |
| cmd_rej_valid | output | 1 | Reject pulse from the command stage |
| cmd_rej_src | output | 24 | Source rejected by the command stage |
| offer_rej_valid | output | 1 | Reject pulse from the offer stage |
| offer_rej_src | output | 24 | Source rejected by the offer stage |
| resend_req | output | 1 | Resend request pulse to the source layer |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source layer |
| eoi_src | output | 24 | Source number carried by the end-of-interrupt |

## Verification
Directed sequences cover the cases that random stimulus rarely reaches in order:
- a more favoured offer displacing a pending one, and a less favoured offer being bounced;
- a message priority write that must not disturb a more favoured pending interrupt;
- an end-of-interrupt whose resend loads the inter-processor interrupt;
- a ceiling drop that flushes the pending interrupt;
- a ceiling raise whose resend loads an interrupt that a same-cycle offer then displaces.

Random stimulus then mixes all four commands with offers whose priorities are drawn from a narrow band. This makes ties with the ceiling, the pending priority and the message priority frequent. Every output is compared each cycle against a model built from the requirements, which separates the two reject channels and the ordering of command before offer.

// File: rtl/xicp_pkg.sv
package xicp_pkg;
    parameter int SRC_W  = 24;
    parameter int PRIO_W = 8;
    localparam int WORD_W = SRC_W + PRIO_W;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam src_t  IPI_SRC    = src_t'(2);
    localparam prio_t PRIO_LEAST = '1;

    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_EOI      = 2'd1,
        OP_SET_CPPR = 2'd2,
        OP_SET_MFRR = 2'd3
    } op_e;

    // Presentation state: ceiling, pending number/priority, message priority, line
    typedef struct packed {
        prio_t cppr;
        src_t  xisr;
        prio_t pend;
        prio_t mfrr;
        logic  irq;
    } pres_t;

    typedef struct packed {
        logic vld;
        src_t src;
    } evt_t;

    typedef struct packed {
        pres_t st;
        evt_t  rej;
    } step_t;

    localparam pres_t RESET_ST = '{cppr: '0, xisr: '0, pend: PRIO_LEAST,
                                   mfrr: PRIO_LEAST, irq: 1'b0};

    function automatic logic busy(input pres_t s);
        return s.xisr != '0;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input pres_t s);
        return {s.cppr, s.xisr};
    endfunction

    // Load the inter-processor interrupt unless a more favoured one waits
    function automatic step_t ipi_check(input pres_t s);
        step_t r;
        r.st  = s;
        r.rej = '0;
        if (!(busy(s) && (s.pend <= s.mfrr))) begin
            if (busy(s)) begin
                r.rej.vld = 1'b1;
                r.rej.src = s.xisr;
            end
            r.st.xisr = IPI_SRC;
            r.st.pend = s.mfrr;
            r.st.irq  = 1'b1;
        end
        return r;
    endfunction

    function automatic step_t resend_scan(input pres_t s);
        step_t r;
        r.st  = s;
        r.rej = '0;
        if (s.mfrr < s.cppr) begin
            r = ipi_check(s);
        end
        return r;
    endfunction
endpackage

// File: rtl/xicp_cmd_stage.sv
module xicp_cmd_stage
    import xicp_pkg::*;
(
    input  pres_t              cur,
    input  logic               cmd_valid,
    input  op_e                cmd_op,
    input  logic [WORD_W-1:0]  cmd_data,
    output pres_t              nxt,
    output evt_t               rej,
    output logic               resend,
    output evt_t               eoi,
    output logic               rd_vld
);
    always_comb begin
        step_t sc;
        prio_t arg;
        sc     = '0;
        arg    = cmd_data[PRIO_W-1:0];
        nxt    = cur;
        rej    = '0;
        resend = 1'b0;
        eoi    = '0;
        rd_vld = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_ACCEPT: begin
                    rd_vld   = 1'b1;
                    nxt.cppr = cur.pend;
                    nxt.xisr = '0;
                    nxt.irq  = 1'b0;
                end
                OP_EOI: begin
                    eoi.vld  = 1'b1;
                    eoi.src  = cmd_data[SRC_W-1:0];
                    nxt.cppr = cmd_data[WORD_W-1:SRC_W];
                    if (!busy(nxt)) begin
                        resend = 1'b1;
                        sc     = resend_scan(nxt);
                        nxt    = sc.st;
                        rej    = sc.rej;
                    end
                end
                OP_SET_CPPR: begin
                    nxt.cppr = arg;
                    if (arg < cur.cppr) begin
                        if (busy(cur) && (arg <= cur.pend)) begin
                            nxt.xisr = '0;
                            nxt.irq  = 1'b0;
                            rej.vld  = 1'b1;
                            rej.src  = cur.xisr;
                        end
                    end else if (!busy(cur)) begin
                        resend = 1'b1;
                        sc     = resend_scan(nxt);
                        nxt    = sc.st;
                        rej    = sc.rej;
                    end
                end
                OP_SET_MFRR: begin
                    nxt.mfrr = arg;
                    if (arg < cur.cppr) begin
                        sc  = ipi_check(nxt);
                        nxt = sc.st;
                        rej = sc.rej;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xicp_offer_stage.sv
module xicp_offer_stage
    import xicp_pkg::*;
(
    input  pres_t cur,
    input  logic  offer_valid,
    input  src_t  offer_src,
    input  prio_t offer_prio,
    output pres_t nxt,
    output evt_t  rej
);
    logic bounce;

    always_comb begin
        bounce = (offer_prio >= cur.cppr) || (busy(cur) && (cur.pend <= offer_prio));
        nxt    = cur;
        rej    = '0;
        if (offer_valid) begin
            if (bounce) begin
                rej.vld = 1'b1;
                rej.src = offer_src;
            end else begin
                if (busy(cur)) begin
                    rej.vld = 1'b1;
                    rej.src = cur.xisr;
                end
                nxt.xisr = offer_src;
                nxt.pend = offer_prio;
                nxt.irq  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xicp_present_unit.sv
module xicp_present_unit
    import xicp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              irq_out,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              cmd_rej_valid,
    output logic [SRC_W-1:0]  cmd_rej_src,
    output logic              offer_rej_valid,
    output logic [SRC_W-1:0]  offer_rej_src,
    output logic              resend_req,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src
);
    pres_t st_q, mid_st, fin_st;
    evt_t  c_rej, o_rej, c_eoi;
    evt_t  c_rej_q, o_rej_q, eoi_q;
    logic  c_resend, c_rd;
    logic  resend_q, rd_q;
    logic [WORD_W-1:0] rd_word_q;

    xicp_cmd_stage u_cmd (
        .cur       (st_q),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e'(cmd_op)),
        .cmd_data  (cmd_data),
        .nxt       (mid_st),
        .rej       (c_rej),
        .resend    (c_resend),
        .eoi       (c_eoi),
        .rd_vld    (c_rd)
    );

    xicp_offer_stage u_offer (
        .cur         (mid_st),
        .offer_valid (offer_valid),
        .offer_src   (offer_src),
        .offer_prio  (offer_prio),
        .nxt         (fin_st),
        .rej         (o_rej)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= RESET_ST;
            c_rej_q   <= '0;
            o_rej_q   <= '0;
            eoi_q     <= '0;
            resend_q  <= 1'b0;
            rd_q      <= 1'b0;
            rd_word_q <= '0;
        end else begin
            st_q     <= fin_st;
            c_rej_q  <= c_rej;
            o_rej_q  <= o_rej;
            eoi_q    <= c_eoi;
            resend_q <= c_resend;
            rd_q     <= c_rd;
            if (c_rd) begin
                rd_word_q <= status_word(st_q);
            end
        end
    end

    assign irq_out         = st_q.irq;
    assign rd_valid        = rd_q;
    assign rd_data         = rd_word_q;
    assign cmd_rej_valid   = c_rej_q.vld;
    assign cmd_rej_src     = c_rej_q.src;
    assign offer_rej_valid = o_rej_q.vld;
    assign offer_rej_src   = o_rej_q.src;
    assign resend_req      = resend_q;
    assign eoi_valid       = eoi_q.vld;
    assign eoi_src         = eoi_q.src;
endmodule

// File: rtl/xicp_present_chk.sv
module xicp_present_chk
    import xicp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [WORD_W-1:0] cmd_data,
    input logic              offer_valid,
    input logic [SRC_W-1:0]  offer_src,
    input logic [PRIO_W-1:0] offer_prio,
    input logic              irq_out,
    input logic              rd_valid,
    input logic              cmd_rej_valid,
    input logic              offer_rej_valid,
    input logic [SRC_W-1:0]  offer_rej_src,
    input logic              resend_req,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  eoi_src
);
    p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_out && !rd_valid && !cmd_rej_valid &&
                        !offer_rej_valid && !resend_req && !eoi_valid));

    p_least_bounced_r2: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && offer_prio == PRIO_LEAST) |=>
        (offer_rej_valid && offer_rej_src == $past(offer_src)));

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(offer_valid || cmd_valid));

    p_accept_read_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ACCEPT && !offer_valid) |=> (rd_valid && !irq_out));

    p_eoi_echo_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_EOI) |=>
        (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));

    // R8: a zero ceiling leaves no room for the message priority to be below it
    p_eoi_zero_ceiling_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_EOI && cmd_data[WORD_W-1:SRC_W] == '0 && !offer_valid)
        |=> !cmd_rej_valid);

    p_resend_cause_r7: assert property (@(posedge clk) disable iff (rst)
        resend_req |-> $past(cmd_valid && (cmd_op == OP_EOI || cmd_op == OP_SET_CPPR)));

    p_rd_cause_r11: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd_valid && cmd_op == OP_ACCEPT));
endmodule

bind xicp_present_unit xicp_present_chk chk_i (.*);

// File: tb/xicp_present_unit_tb_top.sv
module xicp_present_unit_tb_top;
    localparam int CLK_HALF = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_data = 32'd0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = 24'd0;
    logic [7:0]  offer_prio = 8'd0;
    logic        irq_out, rd_valid, cmd_rej_valid, offer_rej_valid, resend_req, eoi_valid;
    logic [31:0] rd_data;
    logic [23:0] cmd_rej_src, offer_rej_src, eoi_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #CLK_HALF clk = ~clk;

    xicp_present_unit dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .irq_out(irq_out), .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_rej_valid(cmd_rej_valid), .cmd_rej_src(cmd_rej_src),
        .offer_rej_valid(offer_rej_valid), .offer_rej_src(offer_rej_src),
        .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    // Reference model built from the requirements
    logic [7:0]  m_cppr, m_pend, m_mfrr;
    logic [23:0] m_xisr;
    logic        m_irq;
    logic        e_rdv, e_crv, e_orv, e_rs, e_ev;
    logic [31:0] e_rd;
    logic [23:0] e_crs, e_ors, e_es;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_ipi();
        if (!(m_xisr != 0 && m_pend <= m_mfrr)) begin
            if (m_xisr != 0) begin e_crv = 1; e_crs = m_xisr; end
            m_xisr = 24'd2; m_pend = m_mfrr; m_irq = 1;
        end
    endtask

    task automatic m_resend();
        e_rs = 1;
        if (m_mfrr < m_cppr) m_ipi();
    endtask

    task automatic m_apply(input logic cv, input logic [1:0] op, input logic [31:0] d,
                           input logic ov, input logic [23:0] os, input logic [7:0] opr);
        e_rdv = 0; e_crv = 0; e_orv = 0; e_rs = 0; e_ev = 0;
        e_crs = 0; e_ors = 0; e_es = 0;
        if (cv) begin
            case (op)
                2'd0: begin
                    e_rdv = 1; e_rd = {m_cppr, m_xisr};
                    m_cppr = m_pend; m_xisr = 0; m_irq = 0;
                end
                2'd1: begin
                    e_ev = 1; e_es = d[23:0]; m_cppr = d[31:24];
                    if (m_xisr == 0) m_resend();
                end
                2'd2: begin
                    if (d[7:0] < m_cppr) begin
                        m_cppr = d[7:0];
                        if (m_xisr != 0 && d[7:0] <= m_pend) begin
                            e_crv = 1; e_crs = m_xisr; m_xisr = 0; m_irq = 0;
                        end
                    end else begin
                        m_cppr = d[7:0];
                        if (m_xisr == 0) m_resend();
                    end
                end
                default: begin
                    m_mfrr = d[7:0];
                    if (m_mfrr < m_cppr) m_ipi();
                end
            endcase
        end
        if (ov) begin
            if (opr >= m_cppr || (m_xisr != 0 && m_pend <= opr)) begin
                e_orv = 1; e_ors = os;
            end else begin
                if (m_xisr != 0) begin e_orv = 1; e_ors = m_xisr; end
                m_xisr = os; m_pend = opr; m_irq = 1;
            end
        end
    endtask

    task automatic step(input logic cv, input logic [1:0] op, input logic [31:0] d,
                        input logic ov, input logic [23:0] os, input logic [7:0] opr);
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        offer_valid = ov; offer_src = os; offer_prio = opr;
        m_apply(cv, op, d, ov, os, opr);
        @(posedge clk);
        #1;
        chk("R3 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
        chk("R4 rd_valid", {31'd0, rd_valid}, {31'd0, e_rdv});
        if (e_rdv) chk("R4 rd_data", rd_data, e_rd);
        chk("R9 cmd_rej_valid", {31'd0, cmd_rej_valid}, {31'd0, e_crv});
        if (e_crv) chk("R9 cmd_rej_src", {8'd0, cmd_rej_src}, {8'd0, e_crs});
        chk("R2 offer_rej_valid", {31'd0, offer_rej_valid}, {31'd0, e_orv});
        if (e_orv) chk("R2 offer_rej_src", {8'd0, offer_rej_src}, {8'd0, e_ors});
        chk("R7 resend_req", {31'd0, resend_req}, {31'd0, e_rs});
        chk("R5 eoi_valid", {31'd0, eoi_valid}, {31'd0, e_ev});
        if (e_ev) chk("R5 eoi_src", {8'd0, eoi_src}, {8'd0, e_es});
        cmd_valid = 0; offer_valid = 0;
    endtask

    function automatic logic [7:0] pick_prio();
        int r = $urandom_range(0, 9);
        return (r == 0) ? 8'hFF : 8'($urandom_range(0, 12));
    endfunction

    initial begin
        repeat (CLK_HALF * 2 * 200000) #1;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_cppr = 0; m_xisr = 0; m_pend = 8'hFF; m_mfrr = 8'hFF; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: quiet after reset
        chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        chk("R1 pulses after reset", {26'd0, rd_valid, cmd_rej_valid, offer_rej_valid,
                                      resend_req, eoi_valid, irq_out}, 32'd0);
        step(1, 2'd0, 0, 0, 0, 0);
        chk("R1 accept after reset", rd_data, 32'h0000_0000);
        // R3 / R2: take, bounce, displace
        step(0, 0, 0, 1, 24'd100, 8'd5);
        chk("R3 offer taken", {31'd0, irq_out}, 32'd1);
        step(0, 0, 0, 1, 24'd101, 8'd7);
        chk("R2 offer bounced", {8'd0, offer_rej_src}, 32'd101);
        step(0, 0, 0, 1, 24'd102, 8'd3);
        chk("R3 displaced source", {8'd0, offer_rej_src}, 32'd100);
        // R9: message priority behind a more favoured pending interrupt
        step(1, 2'd3, 32'd5, 0, 0, 0);
        chk("R9 no-op check", {31'd0, cmd_rej_valid}, 32'd0);
        step(1, 2'd0, 0, 0, 0, 0);
        chk("R4 status word", rd_data, 32'hFF00_0066);
        step(1, 2'd3, 32'd1, 0, 0, 0);
        chk("R9 ipi loaded", {31'd0, irq_out}, 32'd1);
        step(1, 2'd0, 0, 0, 0, 0);
        chk("R4 ipi word", rd_data, 32'h0300_0002);
        // R5 / R8: EOI then resend loads the IPI
        step(1, 2'd1, 32'hFF00_0002, 0, 0, 0);
        chk("R5 eoi source", {8'd0, eoi_src}, 32'd2);
        chk("R8 resend loads ipi", {31'd0, irq_out}, 32'd1);
        // R6: drop the ceiling below the pending priority
        step(1, 2'd2, 32'd0, 0, 0, 0);
        chk("R6 flushed source", {8'd0, cmd_rej_src}, 32'd2);
        chk("R6 line dropped", {31'd0, irq_out}, 32'd0);
        // R10: ceiling raise loads IPI, same-cycle offer displaces it
        step(1, 2'd2, 32'hFF, 1, 24'd77, 8'd0);
        chk("R10 ipi displaced by offer", {8'd0, offer_rej_src}, 32'd2);
        chk("R7 resend on raise", {31'd0, resend_req}, 32'd1);
        step(1, 2'd0, 0, 0, 0, 0);
        chk("R10 offer won", rd_data, 32'hFF00_004D);
        // R11: pulses last one cycle
        step(0, 0, 0, 0, 0, 0);
        chk("R11 pulses cleared", {27'd0, rd_valid, cmd_rej_valid, offer_rej_valid,
                                   resend_req, eoi_valid}, 32'd0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  op = 2'($urandom_range(0, 3));
            logic [31:0] d  = {pick_prio(), 24'($urandom_range(1, 40))};
            if (op != 2'd1) d = {24'd0, pick_prio()};
            step(($urandom_range(0, 2) != 0), op, d,
                 ($urandom_range(0, 1) != 0), 24'($urandom_range(1, 40)), pick_prio());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule